// File: doc/BRIEF.md
# Relocatable Script Memory

A 4 KB on-chip store of 32-bit words that holds the controller's microcode. It has two access paths. The internal path serves the sequencer: instruction fetches, table-indirect fetches and load/store operations that land in the memory window are answered on chip one cycle later. Any other kind of internal access, and any internal access that misses the window, is handed to the host bus through a steering request.

The host path is a slave port. A host bus master reaches the memory at byte granularity through a 4 KB window. The window's base sits in a host-writable register and can be moved anywhere in the 32-bit space. Memory cycles complete after a short, fixed number of target wait states. The same port also reaches three control registers: the window base, a control word, and a scratch word. The scratch word can be switched to return the window base instead of its own contents. When the control word disables the memory, host cycles inside the window are not claimed and internal fetches go out to the host bus.

Top module: `script_mem_top`

## Requirements
- R1: The memory holds 1024 words of 32 bits, and word index = address bits [11:2]. A word written from the host reads back unchanged through the host port and through the internal port, including the last word at offset 0xFFC.
- R2: On a host memory write, host_be_i bit k alone decides whether data bits [8k+7:8k] are stored. Bytes whose enable is 0 keep their old value.
- R3: Number the clock edge at which a claimed request is first sampled as edge 0. If there is no contention, host_ack_o is high for exactly one cycle, starting at edge W, with host_rdata_o valid in that cycle. W is 3 for a memory cycle (host_reg_i=0) and 5 for a register cycle (host_reg_i=1). The host holds its inputs until the acknowledge and then drops host_req_i.
- R4: Register cycles use host_addr_i[3:2] to pick the register: 0 is the base, 1 is control, 2 is scratch, and 3 reads as zero. In the control word, bit 0 enables the memory and resets to 1, and bit 3 is the mirror select and resets to 0. The base and scratch registers reset to 0. Writes to base bits [11:0] are ignored, and those bits read as 0.
- R5: A host memory cycle is claimed (host_claim_o=1) only when host_addr_i[31:12] equals base[31:12] and the memory is enabled. Register cycles are always claimed.
- R6: While control bit 3 is 1, a scratch read returns the base register. While it is 0, a scratch read returns the scratch contents.
- R7: An internal access of kind 0 (fetch), 1 (table) or 2 (load/store) that hits the enabled window is served locally. For these, ext_req_o stays 0 and a read raises int_rvalid_o with the word one cycle later. int_we_i is honoured only for kind 2, and it writes the full word.
- R8: An internal access of kind 3 (other data move), or any access that misses the window, raises ext_req_o in the same cycle and never raises int_rvalid_o.
- R9: While the memory is disabled, host memory cycles are neither claimed nor acknowledged, and every internal access raises ext_req_o.
- R10: A locally served internal access takes the memory ahead of the host. A host memory cycle that would reach the memory in such a cycle is held for one more cycle per conflicting cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_req_i | input | 1 | Host cycle request, held until acknowledge |
| host_reg_i | input | 1 | 1 = register space, 0 = memory space |
| host_we_i | input | 1 | Host write |
| host_addr_i | input | 32 | Host byte address |
| host_be_i | input | 4 | Host byte enables |
| host_wdata_i | input | 32 | Host write data |
| host_claim_o | output | 1 | Cycle is decoded as ours |
| host_ack_o | output | 1 | Data phase done, one cycle |
| host_rdata_o | output | 32 | Host read data, valid with acknowledge |
| int_req_i | input | 1 | Sequencer access request |
| int_kind_i | input | 2 | 0 fetch, 1 table, 2 load/store, 3 other |
| int_we_i | input | 1 | Store (kind 2 only) |
| int_addr_i | input | 32 | Sequencer byte address |
| int_wdata_i | input | 32 | Store data |
| int_rvalid_o | output | 1 | Local read data valid |
| int_rdata_o | output | 32 | Local read data |
| ext_req_o | output | 1 | Access must run on the host bus |

## Verification
The bench builds the block with its default parameters: 1024 words, 3 memory wait states and 5 register wait states. These defaults put the last word at offset 0xFFC in reach, and they make the full wait counts of 3 and 5 visible as exact acknowledge cycles. Relocating the base to 0x80001000 exercises the upper-bit compare. A two-cycle burst of internal fetches, timed to land on the host's final wait state, makes the arbitration delay measurable as an exact cycle count.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'd0,
    K_TABLE = 2'd1,
    K_LDST  = 2'd2,
    K_OTHER = 2'd3
  } int_kind_e;

  typedef enum logic [1:0] {
    RS_BASE = 2'd0,
    RS_CTRL = 2'd1,
    RS_SCR  = 2'd2,
    RS_NONE = 2'd3
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_MIR_BIT = 3;
endpackage

// File: rtl/smem_ram.sv
module smem_ram #(
  parameter int WORDS  = 1024,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(WORDS),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] mem_q [WORDS];

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (en_i && we_i && be_i[b]) mem_q[idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i && !we_i) q_o <= mem_q[idx_i];
  end
endmodule

// File: rtl/smem_regs.sv
module smem_regs
  import smem_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int WIN_LSB = 12,
  localparam int BE_W   = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        sel_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              en_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] BASE_MASK = ~((ADDR_W'(1) << WIN_LSB) - ADDR_W'(1));

  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] scr_q, rd_d;
  logic              en_q, mir_q;
  reg_sel_e          sel;

  assign sel = reg_sel_e'(sel_i);

  function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old_v,
                                              logic [DATA_W-1:0] new_v,
                                              logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    r = old_v;
    for (int k = 0; k < BE_W; k++) if (be[k]) r[8*k +: 8] = new_v[8*k +: 8];
    return r;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      scr_q  <= '0;
      en_q   <= 1'b1;
      mir_q  <= 1'b0;
    end else if (wr_i) begin
      unique case (sel)
        RS_BASE: base_q <= merge(base_q, wdata_i, be_i) & BASE_MASK;
        RS_SCR:  scr_q  <= merge(scr_q, wdata_i, be_i);
        RS_CTRL: if (be_i[0]) begin
          en_q  <= wdata_i[CTRL_EN_BIT];
          mir_q <= wdata_i[CTRL_MIR_BIT];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_d = '0;
    unique case (sel)
      RS_BASE: rd_d = base_q;
      RS_CTRL: begin
        rd_d[CTRL_EN_BIT]  = en_q;
        rd_d[CTRL_MIR_BIT] = mir_q;
      end
      RS_SCR:  rd_d = mir_q ? base_q : scr_q;
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_d;
  end

  assign base_o = base_q;
  assign en_o   = en_q;

  a_r6_mirror_returns_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == RS_SCR && mir_q) |=> (rdata_o == $past(base_q)));
  a_r4_base_low_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == RS_BASE) |=> (rdata_o[WIN_LSB-1:0] == '0));
endmodule

// File: rtl/smem_host_seq.sv
module smem_host_seq #(
  parameter int MEM_WAIT = 3,
  parameter int REG_WAIT = 5,
  localparam int MAX_W   = (MEM_WAIT > REG_WAIT) ? MEM_WAIT : REG_WAIT,
  localparam int CNT_W   = $clog2(MAX_W + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic claim_i,
  input  logic is_reg_i,
  input  logic grant_i,
  output logic go_o,
  output logic ack_o
);
  typedef enum logic [1:0] {H_IDLE, H_WAIT, H_ACK} hstate_e;

  hstate_e          state_q;
  logic [CNT_W-1:0] cnt_q, lim;

  assign lim  = is_reg_i ? CNT_W'(REG_WAIT - 1) : CNT_W'(MEM_WAIT - 1);
  assign go_o = (state_q == H_WAIT) && (cnt_q == lim) && (is_reg_i || grant_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= H_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        H_IDLE: if (req_i && claim_i) begin
          state_q <= H_WAIT;
          cnt_q   <= '0;
        end
        H_WAIT: begin
          if (go_o)            state_q <= H_ACK;
          else if (cnt_q != lim) cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= H_IDLE;
      endcase
    end
  end

  assign ack_o = (state_q == H_ACK);

  a_r3_single_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r3_no_early_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == H_WAIT && cnt_q != lim) |=> !ack_o);
  a_r10_held_without_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == H_WAIT && !is_reg_i && !grant_i) |=> !ack_o);
endmodule

// File: rtl/smem_router.sv
module smem_router
  import smem_pkg::*;
(
  input  logic       req_i,
  input  logic [1:0] kind_i,
  input  logic       hit_i,
  input  logic       en_i,
  output logic       local_o,
  output logic       ext_o
);
  int_kind_e kind;
  logic      kind_local;

  assign kind = int_kind_e'(kind_i);

  always_comb begin
    unique case (kind)
      K_FETCH, K_TABLE, K_LDST: kind_local = 1'b1;
      default:                  kind_local = 1'b0;
    endcase
  end

  assign local_o = req_i && en_i && hit_i && kind_local;
  assign ext_o   = req_i && !local_o;
endmodule

// File: rtl/script_mem_top.sv
module script_mem_top
  import smem_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WORDS    = 1024,
  parameter int MEM_WAIT = 3,
  parameter int REG_WAIT = 5,
  localparam int BE_W    = DATA_W / 8,
  localparam int BYTE_LSB = $clog2(BE_W),
  localparam int IDX_W   = $clog2(WORDS),
  localparam int WIN_LSB = IDX_W + BYTE_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_req_i,
  input  logic              host_reg_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [BE_W-1:0]   host_be_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic              host_claim_o,
  output logic              host_ack_o,
  output logic [DATA_W-1:0] host_rdata_o,
  input  logic              int_req_i,
  input  logic [1:0]        int_kind_i,
  input  logic              int_we_i,
  input  logic [ADDR_W-1:0] int_addr_i,
  input  logic [DATA_W-1:0] int_wdata_i,
  output logic              int_rvalid_o,
  output logic [DATA_W-1:0] int_rdata_o,
  output logic              ext_req_o
);
  logic [ADDR_W-1:0] base;
  logic [DATA_W-1:0] reg_rd, ram_q, ram_wd;
  logic [IDX_W-1:0]  ram_idx;
  logic [BE_W-1:0]   ram_be;
  logic              mem_en, host_hit, int_hit, int_local, int_write;
  logic              host_go, host_mem_go, ram_en, ram_we;
  logic              ack_reg_q, rvalid_q;

  assign host_hit = host_addr_i[ADDR_W-1:WIN_LSB] == base[ADDR_W-1:WIN_LSB];
  assign int_hit  = int_addr_i[ADDR_W-1:WIN_LSB]  == base[ADDR_W-1:WIN_LSB];
  assign host_claim_o = host_req_i && (host_reg_i || (mem_en && host_hit));

  smem_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LSB(WIN_LSB)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (host_go && host_reg_i && host_we_i),
    .rd_i    (host_go && host_reg_i && !host_we_i),
    .sel_i   (host_addr_i[3:2]),
    .be_i    (host_be_i),
    .wdata_i (host_wdata_i),
    .base_o  (base),
    .en_o    (mem_en),
    .rdata_o (reg_rd)
  );

  smem_router u_router (
    .req_i   (int_req_i),
    .kind_i  (int_kind_i),
    .hit_i   (int_hit),
    .en_i    (mem_en),
    .local_o (int_local),
    .ext_o   (ext_req_o)
  );

  smem_host_seq #(.MEM_WAIT(MEM_WAIT), .REG_WAIT(REG_WAIT)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (host_req_i),
    .claim_i  (host_claim_o),
    .is_reg_i (host_reg_i),
    .grant_i  (!int_local),
    .go_o     (host_go),
    .ack_o    (host_ack_o)
  );

  // internal port owns the memory whenever it is served locally
  assign int_write   = int_we_i && (int_kind_e'(int_kind_i) == K_LDST);
  assign host_mem_go = host_go && !host_reg_i;
  assign ram_en      = int_local || host_mem_go;
  assign ram_we      = int_local ? int_write : host_we_i;
  assign ram_idx     = int_local ? int_addr_i[WIN_LSB-1:BYTE_LSB] : host_addr_i[WIN_LSB-1:BYTE_LSB];
  assign ram_be      = int_local ? '1 : host_be_i;
  assign ram_wd      = int_local ? int_wdata_i : host_wdata_i;

  smem_ram #(.WORDS(WORDS), .DATA_W(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (ram_en),
    .we_i    (ram_we),
    .be_i    (ram_be),
    .idx_i   (ram_idx),
    .wdata_i (ram_wd),
    .q_o     (ram_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_reg_q <= 1'b0;
      rvalid_q  <= 1'b0;
    end else begin
      if (host_go) ack_reg_q <= host_reg_i;
      rvalid_q <= int_local && !int_write;
    end
  end

  assign int_rvalid_o = rvalid_q;
  assign int_rdata_o  = rvalid_q ? ram_q : '0;
  assign host_rdata_o = host_ack_o ? (ack_reg_q ? reg_rd : ram_q) : '0;

  logic unused_addr;
  assign unused_addr = ^{host_addr_i[BYTE_LSB-1:0], int_addr_i[BYTE_LSB-1:0]};

  a_r10_one_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(int_local && host_mem_go));
  a_r7_local_read_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_local && !int_write) |=> int_rvalid_o);
  a_r8_steered_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_req_o |=> !int_rvalid_o);
  a_r9_disabled_goes_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_en && int_req_i) |-> ext_req_o);
  a_r9_disabled_no_mem_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_en && host_req_i && !host_reg_i) |-> !host_claim_o);
endmodule

// File: tb/script_mem_top_bench.sv
module script_mem_top_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        h_req = 0, h_reg = 0, h_we = 0;
  logic [31:0] h_addr = '0, h_wd = '0;
  logic [3:0]  h_be = '0;
  logic        h_claim, h_ack;
  logic [31:0] h_rd;
  logic        i_req = 0, i_we = 0;
  logic [1:0]  i_kind = '0;
  logic [31:0] i_addr = '0, i_wd = '0;
  logic        i_rv, e_req;
  logic [31:0] i_rd;
  int          n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  script_mem_top u_script_mem_top (
    .clk_i(clk), .rst_ni(rst_n),
    .host_req_i(h_req), .host_reg_i(h_reg), .host_we_i(h_we), .host_addr_i(h_addr),
    .host_be_i(h_be), .host_wdata_i(h_wd), .host_claim_o(h_claim), .host_ack_o(h_ack),
    .host_rdata_o(h_rd), .int_req_i(i_req), .int_kind_i(i_kind), .int_we_i(i_we),
    .int_addr_i(i_addr), .int_wdata_i(i_wd), .int_rvalid_o(i_rv), .int_rdata_o(i_rd),
    .ext_req_o(e_req)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_cyc(input bit isreg, input bit we, input logic [31:0] a, input logic [3:0] be,
                          input logic [31:0] wd, output logic [31:0] rd, output int n, output bit cl);
    @(negedge clk);
    h_req = 1; h_reg = isreg; h_we = we; h_addr = a; h_be = be; h_wd = wd;
    #1 cl = h_claim;
    n = 0; rd = '0;
    while (n < 20) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (h_ack) begin rd = h_rd; break; end
    end
    h_req = 0;
    @(posedge clk); @(negedge clk);
  endtask

  typedef struct packed {
    logic        isreg;
    logic        we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  n;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    {1'b1, 1'b1, 32'h0000_0000, 4'hF, 32'h8000_1ABC, 32'h0,          4'd6},
    {1'b1, 1'b0, 32'h0000_0000, 4'hF, 32'h0,         32'h8000_1000, 4'd6},
    {1'b0, 1'b1, 32'h8000_1010, 4'hF, 32'h1122_3344, 32'h0,          4'd4},
    {1'b0, 1'b0, 32'h8000_1010, 4'hF, 32'h0,         32'h1122_3344, 4'd4},
    {1'b0, 1'b1, 32'h8000_1010, 4'h5, 32'hAABB_CCDD, 32'h0,          4'd4},
    {1'b0, 1'b0, 32'h8000_1010, 4'hF, 32'h0,         32'h11BB_33DD, 4'd4},
    {1'b0, 1'b1, 32'h8000_1FFC, 4'hF, 32'hCAFE_F00D, 32'h0,          4'd4},
    {1'b0, 1'b0, 32'h8000_1FFC, 4'hF, 32'h0,         32'hCAFE_F00D, 4'd4},
    {1'b1, 1'b0, 32'h0000_0004, 4'hF, 32'h0,         32'h0000_0001, 4'd6},
    {1'b1, 1'b1, 32'h0000_0008, 4'hF, 32'h1234_5678, 32'h0,          4'd6},
    {1'b1, 1'b0, 32'h0000_0008, 4'hF, 32'h0,         32'h1234_5678, 4'd6},
    {1'b1, 1'b1, 32'h0000_0004, 4'hF, 32'h0000_0009, 32'h0,          4'd6},
    {1'b1, 1'b0, 32'h0000_0008, 4'hF, 32'h0,         32'h8000_1000, 4'd6},
    {1'b1, 1'b1, 32'h0000_0004, 4'hF, 32'h0000_0001, 32'h0,          4'd6},
    {1'b1, 1'b0, 32'h0000_0008, 4'hF, 32'h0,         32'h1234_5678, 4'd6}
  };

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int          n;
    bit          cl;

    repeat (3) @(negedge clk);
    // R4: reset state at the ports
    chk(!h_ack && !i_rv && !e_req && !h_claim, "R4 reset outputs", {h_ack, i_rv, e_req, h_claim}, 32'h0);
    rst_n = 1;
    host_cyc(1, 0, 32'h0, 4'hF, 0, rd, n, cl);
    chk(rd == 32'h0, "R4 base reset", rd, 32'h0);
    host_cyc(1, 0, 32'h4, 4'hF, 0, rd, n, cl);
    chk(rd == 32'h1, "R4 ctrl reset", rd, 32'h1);

    // R1 R2 R3 R4 R6: vector walk
    for (int v = 0; v < NV; v++) begin
      host_cyc(VECS[v].isreg, VECS[v].we, VECS[v].addr, VECS[v].be, VECS[v].wd, rd, n, cl);
      chk(cl, $sformatf("R5 claim vec %0d", v), 32'(cl), 32'h1);
      chk(n == int'(VECS[v].n), $sformatf("R3 ack cycle vec %0d", v), n, 32'(VECS[v].n));
      if (!VECS[v].we)
        chk(rd == VECS[v].exp, $sformatf("R1/R2/R6 read vec %0d", v), rd, VECS[v].exp);
    end

    // R7: local fetch of a host-written word
    @(negedge clk); i_req = 1; i_kind = 2'd0; i_addr = 32'h8000_1010; i_we = 0;
    #1 chk(!e_req, "R7 fetch stays local", 32'(e_req), 32'h0);
    @(negedge clk); i_req = 0;
    chk(i_rv && i_rd == 32'h11BB_33DD, "R7 fetch data", i_rd, 32'h11BB_33DD);
    // R7: table fetch of last word, R1 boundary
    i_req = 1; i_kind = 2'd1; i_addr = 32'h8000_1FFC;
    @(negedge clk); i_req = 0;
    chk(i_rv && i_rd == 32'hCAFE_F00D, "R7 R1 table last word", i_rd, 32'hCAFE_F00D);
    // R7: store then host read
    i_req = 1; i_kind = 2'd2; i_we = 1; i_addr = 32'h8000_1020; i_wd = 32'h5A5A_A5A5;
    @(negedge clk); i_req = 0; i_we = 0;
    chk(!i_rv, "R7 store gives no rvalid", 32'(i_rv), 32'h0);
    host_cyc(0, 0, 32'h8000_1020, 4'hF, 0, rd, n, cl);
    chk(rd == 32'h5A5A_A5A5, "R7 store written", rd, 32'h5A5A_A5A5);
    // R7: write on fetch kind ignored
    @(negedge clk); i_req = 1; i_kind = 2'd0; i_we = 1; i_addr = 32'h8000_1020; i_wd = 32'h0;
    @(negedge clk); i_req = 0; i_we = 0;
    host_cyc(0, 0, 32'h8000_1020, 4'hF, 0, rd, n, cl);
    chk(rd == 32'h5A5A_A5A5, "R7 fetch write ignored", rd, 32'h5A5A_A5A5);

    // R8: other kind in window, and miss
    @(negedge clk); i_req = 1; i_kind = 2'd3; i_addr = 32'h8000_1010;
    #1 chk(e_req, "R8 other kind steered", 32'(e_req), 32'h1);
    @(negedge clk);
    chk(!i_rv, "R8 no rvalid", 32'(i_rv), 32'h0);
    i_kind = 2'd0; i_addr = 32'h8000_2010;
    #1 chk(e_req, "R8 miss steered", 32'(e_req), 32'h1);
    @(negedge clk); i_req = 0;
    chk(!i_rv, "R8 miss no rvalid", 32'(i_rv), 32'h0);

    // R5: host miss outside relocated window
    host_cyc(0, 0, 32'h0000_1010, 4'hF, 0, rd, n, cl);
    chk(!cl && n == 20, "R5 miss not claimed", {cl, 31'(n)}, 32'd20);

    // R10: internal fetches on the host's last two wait cycles
    @(negedge clk);
    h_req = 1; h_reg = 0; h_we = 0; h_addr = 32'h8000_1FFC; h_be = 4'hF;
    n = 0; rd = '0;
    while (n < 20) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (h_ack) begin rd = h_rd; break; end
      if (n == 3) begin i_req = 1; i_kind = 2'd0; i_addr = 32'h8000_1010; end
      if (n == 5) i_req = 0;
    end
    h_req = 0; i_req = 0;
    chk(n == 6, "R10 host delayed two cycles", n, 32'd6);
    chk(rd == 32'hCAFE_F00D, "R10 host data intact", rd, 32'hCAFE_F00D);
    @(posedge clk); @(negedge clk);

    // R9: disable memory
    host_cyc(1, 1, 32'h4, 4'hF, 32'h0, rd, n, cl);
    host_cyc(0, 0, 32'h8000_1010, 4'hF, 0, rd, n, cl);
    chk(!cl && n == 20, "R9 disabled host unclaimed", {cl, 31'(n)}, 32'd20);
    @(negedge clk); i_req = 1; i_kind = 2'd0; i_addr = 32'h8000_1010;
    #1 chk(e_req, "R9 disabled fetch steered", 32'(e_req), 32'h1);
    @(negedge clk); i_req = 0;
    chk(!i_rv, "R9 disabled no rvalid", 32'(i_rv), 32'h0);
    host_cyc(1, 1, 32'h4, 4'hF, 32'h1, rd, n, cl);
    host_cyc(0, 0, 32'h8000_1010, 4'hF, 0, rd, n, cl);
    chk(cl && rd == 32'h11BB_33DD, "R9 re-enabled contents kept", rd, 32'h11BB_33DD);

    // R4: register 3 reads zero
    host_cyc(1, 0, 32'hC, 4'hF, 0, rd, n, cl);
    chk(rd == 32'h0, "R4 unused register", rd, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule